// File: doc/BRIEF.md
# Serial Audio Receiver with Error-Flag Insertion

This block takes stereo serial audio from an optical-disc decoder and turns each channel's half-frame into one parallel word. The decoder sends 16-bit samples left-justified: the most significant bit arrives on the first bit-clock sampling edge after the word clock changes level, with no one-bit delay. Beside the data, the decoder drives two per-word quality flags. One marks an uncorrectable error and the other marks a concealed sample. The receiver samples both flags along with the data.

Each received word is 18 bits wide. The sample sits in the upper 16 bits, MSB first. When flag insertion is on, the two low bits carry the error flag and the concealment flag of that same sample. Host logic can use these bits to mask bad samples or to feed a shock-protection buffer. All serial pins are oversampled by the system clock through synchronisers. The bit clock can be inverted so that data are taken on its falling edge instead of its rising edge. The result is presented as a one-cycle valid strobe, together with the word and a channel tag.

Top module: `serial_flag_rx`

## Requirements
- R1: While `rst_n` is low, `rx_valid`, `rx_word` and `rx_right` are all zero.
- R2: For each complete half-frame, `rx_word[17:2]` equals the 16 serial bits in arrival order. The first bit sampled after a word-clock level change lands in bit 17, and the sixteenth lands in bit 2.
- R3: With `flag_en` high, `rx_word[1]` is the OR of the error-flag pin sampled on the first (MSB) bit and on the sixteenth (LSB) bit.
- R4: With `flag_en` high, `rx_word[0]` equals the concealment-flag pin sampled on the sixteenth (LSB) bit.
- R5: With `flag_en` low, `rx_word[1:0]` is 00 whatever the flag pins carry.
- R6: With `sclk_inv` low, pins are sampled on the rising edge of `sclk_pin`. With `sclk_inv` high, they are sampled on the falling edge.
- R7: After the sixteenth bit of a half-frame, `rx_valid` pulses high for exactly one clock. Bit-clock edges after the sixteenth, up to the next word-clock change, change neither the outputs nor the count of pulses. `rx_word` and `rx_right` hold their values between pulses.
- R8: `rx_right` is 1 when the word clock was high during the word and 0 when it was low.
- R9: After reset, the half-frame in which the first bit-clock edge falls produces no word, because it has no preceding word-clock change. A half-frame cut short by a word-clock change before its sixteenth bit also produces no word.
- R10: The error-flag pin on bits 2 through 15 of a half-frame, and the concealment-flag pin on bits 1 through 15, have no effect on `rx_word[1:0]`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_en | input | 1 | Enables insertion of the two flags into the low bits |
| sclk_inv | input | 1 | Inverts the bit clock before edge detection |
| sclk_pin | input | 1 | Serial bit clock from the decoder |
| lrck_pin | input | 1 | Word clock; level selects channel, change starts a word |
| sdata_pin | input | 1 | Serial data, MSB first |
| ef_pin | input | 1 | Per-bit error flag from the decoder |
| cflg_pin | input | 1 | Per-bit concealment flag from the decoder |
| rx_valid | output | 1 | One-cycle strobe marking a new word |
| rx_word | output | 18 | Sample in [17:2], error flag in [1], concealment flag in [0] |
| rx_right | output | 1 | Channel tag of the word (1 = word clock high) |

## Verification
The sweep walks single set and cleared bits through every sample position, so a shifter that is off by one place or reversed shows up as a wrong data field. On every half-frame the error-flag pin is driven independently on the MSB, the middle bits and the LSB, and the concealment flag on the middle bits is the opposite of its LSB value. A design that samples the flags on the wrong edge, or ORs in the middle bits, therefore reports wrong low bits. Short and over-long half-frames are mixed in: a receiver that emits a partial word, or that counts the extra bits into a second word, produces a surplus or shifted word. Every pattern is repeated with each bit-clock polarity and with insertion on and off.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int unsigned SRX_DATA_BITS = 16;
  localparam int unsigned SRX_FLAG_BITS = 2;

  typedef struct packed {
    logic lrck;
    logic sdata;
    logic ef;
    logic cflg;
  } srx_lane_t;

  localparam int unsigned SRX_LANE_W = $bits(srx_lane_t);
endpackage

// File: rtl/srx_pin_sync.sv
module srx_pin_sync
  import srx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      sclk_inv,
  input  logic      sclk_pin,
  input  srx_lane_t lane_pin,
  output logic      samp_stb,
  output srx_lane_t lane_s
);
  localparam int unsigned VW = SRX_LANE_W + 1;

  logic [VW-1:0] pin_vec;
  assign pin_vec = {sclk_pin, lane_pin};

  for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
    logic [VW-1:0] d;
    logic [VW-1:0] q;
    if (g == 0) begin : g_first
      assign d = pin_vec;
    end else begin : g_next
      assign d = g_stage[g-1].q;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end
  end

  logic [VW-1:0] sync_vec;
  logic          sclk_s;
  logic          sclk_d_q;
  logic          sclk_d_n;

  assign sync_vec = g_stage[SYNC_STAGES-1].q;
  assign sclk_s   = sync_vec[VW-1] ^ sclk_inv;
  assign lane_s   = srx_lane_t'(sync_vec[SRX_LANE_W-1:0]);

  // Next-state: remember the polarity-corrected bit clock.
  always_comb begin
    sclk_d_n = sclk_s;
  end

  // Reset to 1 so a rising edge needs a low level seen after reset first.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_d_q <= 1'b1;
    else        sclk_d_q <= sclk_d_n;
  end

  assign samp_stb = sclk_s & ~sclk_d_q;
endmodule

// File: rtl/srx_framer.sv
module srx_framer #(
  parameter int unsigned DATA_BITS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic samp_stb,
  input  logic lrck,
  output logic take_msb,
  output logic take_bit,
  output logic take_lsb
);
  localparam int unsigned CW = $clog2(DATA_BITS + 1);
  localparam logic [CW-1:0] CNT_DONE = CW'(DATA_BITS);
  localparam logic [CW-1:0] CNT_LAST = CW'(DATA_BITS - 1);

  logic          primed_q, primed_n;
  logic          lrck_prev_q, lrck_prev_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          lr_change;

  assign lr_change = primed_q && (lrck != lrck_prev_q);
  assign take_msb  = samp_stb && lr_change;
  assign take_bit  = samp_stb && primed_q && !lr_change && (cnt_q < CNT_DONE);
  assign take_lsb  = take_bit && (cnt_q == CNT_LAST);

  always_comb begin
    primed_n    = primed_q;
    lrck_prev_n = lrck_prev_q;
    cnt_n       = cnt_q;
    if (samp_stb) begin
      primed_n    = 1'b1;
      lrck_prev_n = lrck;
      if (!primed_q)     cnt_n = CNT_DONE;
      else if (take_msb) cnt_n = CW'(1);
      else if (take_bit) cnt_n = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed_q    <= 1'b0;
      lrck_prev_q <= 1'b0;
      cnt_q       <= CNT_DONE;
    end else if (samp_stb) begin
      primed_q    <= primed_n;
      lrck_prev_q <= lrck_prev_n;
      cnt_q       <= cnt_n;
    end
  end
endmodule

// File: rtl/srx_packer.sv
module srx_packer
  import srx_pkg::*;
#(
  parameter int unsigned DATA_BITS = 16
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              flag_en,
  input  logic                              take_msb,
  input  logic                              take_bit,
  input  logic                              take_lsb,
  input  srx_lane_t                         lane,
  output logic                              rx_valid,
  output logic [DATA_BITS+SRX_FLAG_BITS-1:0] rx_word,
  output logic                              rx_right
);
  localparam int unsigned WW = DATA_BITS + SRX_FLAG_BITS;

  logic [DATA_BITS-2:0] shift_q, shift_n;
  logic                 ef_msb_q, ef_msb_n;
  logic                 chan_q, chan_n;
  logic                 valid_q, valid_n;
  logic [WW-1:0]        word_q, word_n;
  logic                 right_q, right_n;
  logic [SRX_FLAG_BITS-1:0] flags;
  logic                 shift_en;

  assign shift_en = take_msb || take_bit;
  assign flags    = flag_en ? {ef_msb_q | lane.ef, lane.cflg} : '0;

  always_comb begin
    shift_n  = shift_q;
    ef_msb_n = ef_msb_q;
    chan_n   = chan_q;
    if (take_msb) begin
      shift_n  = {{(DATA_BITS-2){1'b0}}, lane.sdata};
      ef_msb_n = lane.ef;
      chan_n   = lane.lrck;
    end else if (take_bit) begin
      shift_n  = {shift_q[DATA_BITS-3:0], lane.sdata};
    end
  end

  always_comb begin
    valid_n = take_lsb;
    word_n  = word_q;
    right_n = right_q;
    if (take_lsb) begin
      word_n  = {shift_q, lane.sdata, flags};
      right_n = chan_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q  <= '0;
      ef_msb_q <= 1'b0;
      chan_q   <= 1'b0;
    end else if (shift_en) begin
      shift_q  <= shift_n;
      ef_msb_q <= ef_msb_n;
      chan_q   <= chan_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q  <= '0;
      right_q <= 1'b0;
    end else if (take_lsb) begin
      word_q  <= word_n;
      right_q <= right_n;
    end
  end

  assign rx_valid = valid_q;
  assign rx_word  = word_q;
  assign rx_right = right_q;
endmodule

// File: rtl/serial_flag_rx.sv
module serial_flag_rx
  import srx_pkg::*;
#(
  parameter int unsigned DATA_BITS   = SRX_DATA_BITS,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               flag_en,
  input  logic                               sclk_inv,
  input  logic                               sclk_pin,
  input  logic                               lrck_pin,
  input  logic                               sdata_pin,
  input  logic                               ef_pin,
  input  logic                               cflg_pin,
  output logic                               rx_valid,
  output logic [DATA_BITS+SRX_FLAG_BITS-1:0] rx_word,
  output logic                               rx_right
);
  srx_lane_t lane_pin;
  srx_lane_t lane_s;
  logic      samp_stb;
  logic      take_msb, take_bit, take_lsb;

  assign lane_pin = '{lrck: lrck_pin, sdata: sdata_pin, ef: ef_pin, cflg: cflg_pin};

  srx_pin_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_inv (sclk_inv),
    .sclk_pin (sclk_pin),
    .lane_pin (lane_pin),
    .samp_stb (samp_stb),
    .lane_s   (lane_s)
  );

  srx_framer #(.DATA_BITS(DATA_BITS)) u_framer (
    .clk      (clk),
    .rst_n    (rst_n),
    .samp_stb (samp_stb),
    .lrck     (lane_s.lrck),
    .take_msb (take_msb),
    .take_bit (take_bit),
    .take_lsb (take_lsb)
  );

  srx_packer #(.DATA_BITS(DATA_BITS)) u_packer (
    .clk      (clk),
    .rst_n    (rst_n),
    .flag_en  (flag_en),
    .take_msb (take_msb),
    .take_bit (take_bit),
    .take_lsb (take_lsb),
    .lane     (lane_s),
    .rx_valid (rx_valid),
    .rx_word  (rx_word),
    .rx_right (rx_right)
  );
endmodule

// File: rtl/serial_flag_rx_chk.sv
module serial_flag_rx_chk #(
  parameter int unsigned DATA_BITS = 16
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 flag_en,
  input logic                 rx_valid,
  input logic [DATA_BITS+1:0] rx_word,
  input logic                 rx_right
);
  localparam int unsigned MIN_GAP = 2 * DATA_BITS - 1;
  localparam int unsigned GW      = $clog2(MIN_GAP + 1);

  logic [GW-1:0] gap_q;
  logic          seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (rx_valid) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else if (gap_q < GW'(MIN_GAP)) begin
      gap_q  <= gap_q + GW'(1);
    end
  end

  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_quiet_chk: assert (!rx_valid && rx_word == '0 && !rx_right);
    end
  end

  // R7
  valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R7
  word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_word) && $stable(rx_right)));

  // R7
  word_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && seen_q) |-> (gap_q >= GW'(MIN_GAP)));

  // R5
  flags_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && !$past(flag_en)) |-> (rx_word[1:0] == 2'b00));
endmodule

bind serial_flag_rx serial_flag_rx_chk #(.DATA_BITS(DATA_BITS)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .flag_en  (flag_en),
  .rx_valid (rx_valid),
  .rx_word  (rx_word),
  .rx_right (rx_right)
);

// File: tb/serial_flag_rx_tb.sv
`timescale 1ns/1ps
module serial_flag_rx_tb;
  localparam int DW = 16;
  localparam int WW = DW + 2;

  logic clk = 1'b0;
  logic rst_n, flag_en, sclk_inv;
  logic sclk_pin, lrck_pin, sdata_pin, ef_pin, cflg_pin;
  logic rx_valid, rx_right;
  logic [WW-1:0] rx_word;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  bit finished = 0;
  bit lr_lvl = 0;
  logic [WW:0] exp_q[$];

  always #2.5 clk = ~clk;

  serial_flag_rx u_dut (
    .clk(clk), .rst_n(rst_n), .flag_en(flag_en), .sclk_inv(sclk_inv),
    .sclk_pin(sclk_pin), .lrck_pin(lrck_pin), .sdata_pin(sdata_pin),
    .ef_pin(ef_pin), .cflg_pin(cflg_pin),
    .rx_valid(rx_valid), .rx_word(rx_word), .rx_right(rx_right)
  );

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: run hung, got cycle %0d expected below 150000", cycles);
      finish_run();
    end
  end

  // Output monitor: compares every strobe against the expected list.
  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R9 R7: surplus word got %h expected none", rx_word);
      end else begin
        logic [WW:0] e;
        e = exp_q.pop_front();
        checks++;
        if (rx_word[WW-1:2] != e[WW-1:2]) begin
          fails++;
          $display("FAIL %s: data got %h expected %h", sclk_inv ? "R2 R6" : "R2",
                   rx_word[WW-1:2], e[WW-1:2]);
        end
        checks++;
        if (rx_word[1] != e[1]) begin
          fails++;
          $display("FAIL %s: error flag got %b expected %b",
                   flag_en ? "R3 R10" : "R5", rx_word[1], e[1]);
        end
        checks++;
        if (rx_word[0] != e[0]) begin
          fails++;
          $display("FAIL %s: conceal flag got %b expected %b",
                   flag_en ? "R4 R10" : "R5", rx_word[0], e[0]);
        end
        checks++;
        if (rx_right != e[WW]) begin
          fails++;
          $display("FAIL R8: channel got %b expected %b", rx_right, e[WW]);
        end
      end
    end
  end

  // One half-frame; mid bits carry flags that must be ignored (R10).
  task automatic send_half(input logic [DW-1:0] d, input bit e_msb, input bit e_mid,
                           input bit e_lsb, input bit c_lsb, input int nbits,
                           input bit want);
    lr_lvl = ~lr_lvl;
    if (want && nbits >= DW)
      exp_q.push_back({lr_lvl, d, flag_en ? {e_msb | e_lsb, c_lsb} : 2'b00});
    for (int i = 0; i < nbits; i++) begin
      lrck_pin  = lr_lvl;
      sdata_pin = (i < DW) ? d[DW-1-i] : i[0];
      ef_pin    = (i == 0) ? e_msb : (i == DW-1) ? e_lsb : (i < DW) ? e_mid : 1'b1;
      cflg_pin  = (i == DW-1) ? c_lsb : (i < DW) ? ~c_lsb : 1'b1;
      sclk_pin  = sclk_inv;
      #20;
      sclk_pin  = ~sclk_inv;
      #20;
    end
  endtask

  task automatic do_reset(input bit inv);
    rst_n = 0; sclk_inv = inv; sclk_pin = inv;
    lrck_pin = 0; sdata_pin = 0; ef_pin = 0; cflg_pin = 0;
    #40;
    checks++;
    if (rx_valid !== 1'b0 || rx_word !== '0 || rx_right !== 1'b0) begin
      fails++;
      $display("FAIL R1: reset outputs got %b/%h/%b expected 0/0/0",
               rx_valid, rx_word, rx_right);
    end
    rst_n = 1;
    #40;
    // First half-frame after reset only primes the framer (R9).
    send_half(16'h1234, 1, 1, 1, 1, DW, 0);
  endtask

  initial begin
    flag_en = 0;
    for (int inv = 0; inv < 2; inv++) begin
      do_reset(inv[0]);
      for (int fe = 0; fe < 2; fe++) begin
        flag_en = fe[0];
        for (int b = 0; b < DW; b++) begin
          logic [3:0] f;
          f = b[3:0];
          // R2 R7: walking one, sometimes with extra trailing bits
          send_half(16'(1 << b), f[0], f[3], f[1], f[2], DW + (b % 5), 1);
          // R2: walking zero
          send_half(~16'(1 << b), f[1], ~f[3], f[2], f[0], DW, 1);
        end
        for (int k = 0; k < 8; k++) begin
          logic [2:0] f;
          f = k[2:0];
          // R3 R4 R5 R10: every flag combination
          send_half(16'hA5C3 ^ 16'(k * 16'h1111), f[0], 1'b1, f[1], f[2], DW, 1);
        end
        // R9: truncated half-frame yields nothing
        send_half(16'hFFFF, 1, 1, 1, 1, DW - 7, 1);
        send_half(16'h8001, 1, 0, 0, 1, DW, 1);
      end
    end
    #200;
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R7 R9: missing words got %0d pending expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule